// File: doc/BRIEF.md
# Shared-Bus Arbitration and Selection Controller

This controller sits in one device on an 8-bit shared peripheral bus whose control lines are active low and wired so that any device can pull a line to its asserted level. On a start request, the controller waits for the bus to be idle, which means neither BSY nor SEL is asserted. It then contends for the bus by pulling BSY and its own ID lane of the data bus. After a fixed number of cycles it compares its lane against the others. If it wins, it addresses a target by asserting SEL and presenting both ID lanes at once. It then waits for the target to answer by asserting BSY.

The outputs are drive enables. A 1 means "pull this line to its asserted (low) level", so several devices may drive the same line. The sampled line levels come back on the inputs. The same sequence runs in a mirrored form for reselection, where a target reconnects to the initiator it served earlier. In that form the direction line is also asserted for the whole selection phase. What happens on the bus after selection is outside this block.

Top module: `pp_arb_sel_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, all drive enables are 0 and `won`, `lost`, `selected`, `timeout` are 0.
- R2: After `start`, no line is driven until the bus has been sampled idle (`bus_bsy_n`=1 and `bus_sel_n`=1) on FREE_DLY consecutive clock edges. Arbitration starts on the FREE_DLY-th of those edges.
- R3: During arbitration the block drives BSY and exactly one data lane, bit `own_id` (lane i corresponds to `bus_db_n[i]`). It does not drive SEL or the direction line, and this lasts ARB_DLY cycles.
- R4: On the ARB_DLY-th edge of arbitration, the block wins if no data lane above `own_id` is low and SEL is not asserted. Lane 7 is the highest priority. On a win, `won` rises and SEL is driven together with BSY.
- R5: If a higher lane or SEL is seen on that edge, `lost` pulses for one cycle. All drives are released in the same cycle, and the block goes back to waiting for an idle bus and then arbitrates again.
- R6: During selection the data drive is the OR of the own and target lanes. BSY is released one cycle after SEL is first driven, while SEL and the data stay driven.
- R7: If `bus_bsy_n` is sampled low while the block waits for the answer, `selected` pulses for one cycle. In that cycle every drive is released and `won` falls.
- R8: If there is no answer, `timeout` pulses on the SEL_TMO-th edge after BSY was released. In that cycle every drive is released and `won` falls. An answer seen on that same edge counts as selected.
- R9: With `resel`=1 latched at start, the direction line is driven for the whole selection phase. With `resel`=0 it is never driven.
- R10: `start` is ignored while a sequence is in progress: the block returns to idle and stays undriven afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled only when idle) |
| resel | input | 1 | 1: reselection form (direction line driven) |
| own_id | input | 3 | This device's ID, latched at start |
| tgt_id | input | 3 | ID of the device to address, latched at start |
| bus_bsy_n | input | 1 | Sampled BSY line, active low |
| bus_sel_n | input | 1 | Sampled SEL line, active low |
| bus_db_n | input | 8 | Sampled data lanes, active low |
| drv_bsy | output | 1 | Pull BSY low |
| drv_sel | output | 1 | Pull SEL low |
| drv_io | output | 1 | Pull direction line low |
| drv_db | output | 8 | Pull data lanes low |
| won | output | 1 | High while the block owns the bus and is selecting |
| lost | output | 1 | One-cycle pulse: arbitration lost |
| selected | output | 1 | One-cycle pulse: target answered |
| timeout | output | 1 | One-cycle pulse: no answer in time |

## Verification
The properties assume three things about the inputs. `tgt_id` differs from `own_id`. Both IDs hold still for the whole sequence. The sampled bus lines are the wired combination of this block's drives with those of the other devices. Under these assumptions, any foreign low lane or SEL at a loss is a real contender, and an answer always follows the release of BSY. The bench keeps to these assumptions. Each scenario draws a target different from its own ID and keeps both fixed. The lines are formed as a wired-AND of the block's enables and a bench-side contender and target model. Contenders only drive during arbitration and let go as soon as the outcome is known.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;

    localparam int BUS_W = 8;
    localparam int ID_W  = $clog2(BUS_W);

    typedef logic [ID_W-1:0]  dev_id_t;
    typedef logic [BUS_W-1:0] lane_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ARB,
        ST_SELA,
        ST_SELW
    } arb_state_e;

    typedef struct packed {
        logic  bsy;
        logic  sel;
        logic  io;
        lane_t db;
    } line_drive_t;

    typedef struct packed {
        dev_id_t own;
        dev_id_t tgt;
        logic    rs;
    } seq_ctx_t;

    function automatic lane_t id_lane(dev_id_t id);
        lane_t r;
        r     = '0;
        r[id] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pp_free_watch.sv
module pp_free_watch #(
    parameter int FREE_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bsy_n,
    input  logic sel_n,
    output logic free_ok
);
    localparam int CW = $clog2(FREE_DLY + 1);
    localparam logic [CW-1:0] NEED = CW'(FREE_DLY - 1);

    logic          idle_now;
    logic [CW-1:0] run_cnt;

    assign idle_now = bsy_n & sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!idle_now) begin
            run_cnt <= '0;
        end else if (run_cnt != NEED) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign free_ok = idle_now && (run_cnt == NEED);
endmodule

// File: rtl/pp_prio_judge.sv
module pp_prio_judge
    import pp_arb_pkg::*;
(
    input  dev_id_t own,
    input  lane_t   db_n,
    input  logic    sel_n,
    output logic    beaten
);
    lane_t higher;

    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        assign higher[i] = (i > int'(own)) && !db_n[i];
    end

    assign beaten = (|higher) || !sel_n;
endmodule

// File: rtl/pp_tick_timer.sv
module pp_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pp_arb_sel_ctrl.sv
module pp_arb_sel_ctrl
    import pp_arb_pkg::*;
#(
    parameter int FREE_DLY = 2,
    parameter int ARB_DLY  = 3,
    parameter int SEL_TMO  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       resel,
    input  logic [2:0] own_id,
    input  logic [2:0] tgt_id,
    input  logic       bus_bsy_n,
    input  logic       bus_sel_n,
    input  logic [7:0] bus_db_n,
    output logic       drv_bsy,
    output logic       drv_sel,
    output logic       drv_io,
    output logic [7:0] drv_db,
    output logic       won,
    output logic       lost,
    output logic       selected,
    output logic       timeout
);
    localparam int MAXD = (ARB_DLY > SEL_TMO) ? ARB_DLY : SEL_TMO;
    localparam int TW   = $clog2(MAXD + 1);
    localparam logic [TW-1:0] ARB_LAST = TW'(ARB_DLY - 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(SEL_TMO - 1);

    arb_state_e  state, state_nx;
    seq_ctx_t    ctx;
    line_drive_t drv;
    logic        free_ok, beaten;
    logic        tmr_clr, tmr_en;
    logic [TW-1:0] tmr;
    logic        won_nx, lost_nx, sel_nx, tmo_nx;

    pp_free_watch #(.FREE_DLY(FREE_DLY)) u_free (
        .clk(clk), .rst(rst), .bsy_n(bus_bsy_n), .sel_n(bus_sel_n),
        .free_ok(free_ok)
    );

    pp_prio_judge u_judge (
        .own(ctx.own), .db_n(bus_db_n), .sel_n(bus_sel_n), .beaten(beaten)
    );

    pp_tick_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .count(tmr)
    );

    assign tmr_en = (state == ST_ARB) || (state == ST_SELW);

    always_comb begin
        state_nx = state;
        tmr_clr  = 1'b0;
        won_nx   = won;
        lost_nx  = 1'b0;
        sel_nx   = 1'b0;
        tmo_nx   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (free_ok) begin
                    state_nx = ST_ARB;
                    tmr_clr  = 1'b1;
                end
            end
            ST_ARB: begin
                if (tmr == ARB_LAST) begin
                    if (beaten) begin
                        state_nx = ST_WAIT;
                        lost_nx  = 1'b1;
                    end else begin
                        state_nx = ST_SELA;
                        won_nx   = 1'b1;
                    end
                end
            end
            ST_SELA: begin
                state_nx = ST_SELW;
                tmr_clr  = 1'b1;
            end
            ST_SELW: begin
                if (!bus_bsy_n) begin
                    state_nx = ST_IDLE;
                    sel_nx   = 1'b1;
                    won_nx   = 1'b0;
                end else if (tmr == TMO_LAST) begin
                    state_nx = ST_IDLE;
                    tmo_nx   = 1'b1;
                    won_nx   = 1'b0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctx      <= '0;
            won      <= 1'b0;
            lost     <= 1'b0;
            selected <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            state    <= state_nx;
            won      <= won_nx;
            lost     <= lost_nx;
            selected <= sel_nx;
            timeout  <= tmo_nx;
            if (state == ST_IDLE && start) begin
                ctx.own <= own_id;
                ctx.tgt <= tgt_id;
                ctx.rs  <= resel;
            end
        end
    end

    always_comb begin
        drv = '0;
        unique case (state)
            ST_ARB: begin
                drv.bsy = 1'b1;
                drv.db  = id_lane(ctx.own);
            end
            ST_SELA: begin
                drv.bsy = 1'b1;
                drv.sel = 1'b1;
                drv.io  = ctx.rs;
                drv.db  = id_lane(ctx.own) | id_lane(ctx.tgt);
            end
            ST_SELW: begin
                drv.sel = 1'b1;
                drv.io  = ctx.rs;
                drv.db  = id_lane(ctx.own) | id_lane(ctx.tgt);
            end
            default: drv = '0;
        endcase
    end

    assign drv_bsy = drv.bsy;
    assign drv_sel = drv.sel;
    assign drv_io  = drv.io;
    assign drv_db  = drv.db;
endmodule

// File: rtl/pp_arb_sel_chk.sv
module pp_arb_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_bsy_n,
    input logic       bus_sel_n,
    input logic [7:0] bus_db_n,
    input logic       drv_bsy,
    input logic       drv_sel,
    input logic       drv_io,
    input logic [7:0] drv_db,
    input logic       won,
    input logic       lost,
    input logic       selected,
    input logic       timeout
);
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!drv_bsy && !drv_sel && !drv_io && drv_db == 8'h00 && !won));

    p_arb_after_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv_bsy) && !drv_sel) |-> $past(bus_bsy_n && bus_sel_n));

    p_one_lane_in_arb_r3: assert property (@(posedge clk) disable iff (rst)
        (drv_bsy && !drv_sel) |-> ($countones(drv_db) == 1 && !drv_io));

    p_sel_only_when_won_r4: assert property (@(posedge clk) disable iff (rst)
        drv_sel |-> won);

    p_sel_follows_arb_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_sel) |-> $past(drv_bsy));

    p_loss_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        lost |-> $past(!bus_sel_n || ((~bus_db_n & ~drv_db) != 8'h00)));

    p_loss_releases_r5: assert property (@(posedge clk) disable iff (rst)
        lost |-> (!drv_bsy && !drv_sel && drv_db == 8'h00));

    p_two_lanes_in_sel_r6: assert property (@(posedge clk) disable iff (rst)
        drv_sel |-> ($countones(drv_db) == 2));

    p_answer_seen_r7: assert property (@(posedge clk) disable iff (rst)
        selected |-> $past(!bus_bsy_n && drv_sel));

    p_done_releases_r8: assert property (@(posedge clk) disable iff (rst)
        (selected || timeout) |-> (!drv_sel && !drv_io && drv_db == 8'h00 && !won));

    p_single_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lost, selected, timeout}));

    p_dir_only_in_sel_r9: assert property (@(posedge clk) disable iff (rst)
        drv_io |-> drv_sel);
endmodule

bind pp_arb_sel_ctrl pp_arb_sel_chk u_chk (
    .clk(clk), .rst(rst), .bus_bsy_n(bus_bsy_n), .bus_sel_n(bus_sel_n),
    .bus_db_n(bus_db_n), .drv_bsy(drv_bsy), .drv_sel(drv_sel),
    .drv_io(drv_io), .drv_db(drv_db), .won(won), .lost(lost),
    .selected(selected), .timeout(timeout)
);

// File: tb/tb_pp_arb_sel_ctrl.sv
module tb_pp_arb_sel_ctrl;
    localparam int FREE_DLY = 2;
    localparam int ARB_DLY  = 3;
    localparam int SEL_TMO  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, resel = 1'b0;
    logic [2:0] own_id = '0, tgt_id = '0;
    logic       ext_bsy = 1'b0, ext_sel = 1'b0;
    logic [7:0] ext_db = '0;
    logic       bus_bsy_n, bus_sel_n;
    logic [7:0] bus_db_n;
    logic       drv_bsy, drv_sel, drv_io, won, lost, selected, timeout;
    logic [7:0] drv_db;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign bus_bsy_n = ~(drv_bsy | ext_bsy);
    assign bus_sel_n = ~(drv_sel | ext_sel);
    assign bus_db_n  = ~(drv_db | ext_db);

    pp_arb_sel_ctrl #(.FREE_DLY(FREE_DLY), .ARB_DLY(ARB_DLY), .SEL_TMO(SEL_TMO)) dut (
        .clk(clk), .rst(rst), .start(start), .resel(resel),
        .own_id(own_id), .tgt_id(tgt_id),
        .bus_bsy_n(bus_bsy_n), .bus_sel_n(bus_sel_n), .bus_db_n(bus_db_n),
        .drv_bsy(drv_bsy), .drv_sel(drv_sel), .drv_io(drv_io), .drv_db(drv_db),
        .won(won), .lost(lost), .selected(selected), .timeout(timeout)
    );

    function automatic logic [7:0] lane(input logic [2:0] id);
        return 8'h01 << id;
    endfunction

    function automatic logic [7:0] above(input logic [2:0] id);
        return ~((8'h02 << id) - 8'h01);
    endfunction

    function automatic logic [11:0] snap();
        return {drv_bsy, drv_sel, drv_io, drv_db, won};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [2:0] own, input logic [2:0] tgt, input logic [7:0] comp,
                       input bit csel, input bit rs, input int d, input int busy0);
        int  busy = busy0;
        int  j;
        bit  lose;
        logic [11:0] e;
        @(negedge clk);
        own_id = own; tgt_id = tgt; resel = rs; start = 1'b1; ext_bsy = 1'b1;
        step();
        start = 1'b0;
        for (int att = 0; att < 2; att++) begin
            for (int k = 1; k < busy; k++) begin
                step();
                chk(snap() == 12'h0, "R2 busy", snap(), 12'h0);
            end
            ext_bsy = 1'b0; ext_sel = 1'b0; ext_db = '0;
            for (int k = 0; k < FREE_DLY - 1; k++) begin
                step();
                chk(snap() == 12'h0, "R2 settle", snap(), 12'h0);
            end
            e = {1'b1, 1'b0, 1'b0, lane(own), 1'b0};
            for (int k = 0; k < ARB_DLY; k++) begin
                step();
                chk(snap() == e, "R3 arb", snap(), e);
                if (k == 0 && att == 0) begin
                    ext_db = comp; ext_sel = csel; ext_bsy = (comp != 0) || csel;
                end
            end
            step();
            lose = (att == 0) && (((comp & above(own)) != 0) || csel);
            if (lose) begin
                chk(lost && snap() == 12'h0, "R5 loss", {snap()[11:1], lost}, 12'h001);
                ext_bsy = 1'b1; ext_sel = 1'b0; ext_db = '0; busy = 3;
            end else begin
                e = {1'b1, 1'b1, rs, lane(own) | lane(tgt), 1'b1};
                chk(snap() == e && !lost, "R4 R6 R9 win", snap(), e);
                ext_bsy = 1'b0; ext_sel = 1'b0; ext_db = '0;
                break;
            end
        end
        step();
        e = {1'b0, 1'b1, rs, lane(own) | lane(tgt), 1'b1};
        chk(snap() == e, "R6 R9 sel wait", snap(), e);
        j = 0;
        start = 1'b1;
        forever begin
            if (j == d) ext_bsy = 1'b1;
            step();
            if (j == 0) start = 1'b0;
            j++;
            if (selected || timeout || j > SEL_TMO + 1) break;
            chk(snap() == e, "R8 holding", snap(), e);
        end
        if (d < SEL_TMO)
            chk(selected && !timeout && j == d + 1, "R7 answer", 12'(j), 12'(d + 1));
        else
            chk(timeout && !selected && j == SEL_TMO, "R8 timeout", 12'(j), 12'(SEL_TMO));
        chk(snap() == 12'h0, "R7 R8 release", snap(), 12'h0);
        ext_bsy = 1'b0;
        for (int k = 0; k < FREE_DLY + ARB_DLY; k++) begin
            step();
            chk(snap() == 12'h0 && !selected && !timeout, "R10 ignored start", snap(), 12'h0);
        end
    endtask

    initial begin
        while (cyc < 100000 && !done) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd20240611;
        logic [2:0] o, t;
        logic [7:0] c;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(snap() == 12'h0 && !lost && !selected && !timeout, "R1 in reset", snap(), 12'h0);
        rst = 1'b0;
        step();
        chk(snap() == 12'h0 && !lost && !selected && !timeout, "R1 after reset", snap(), 12'h0);

        run(3'd7, 3'd0, 8'h7f, 1'b0, 1'b0, 0, 1);
        run(3'd0, 3'd5, 8'h80, 1'b0, 1'b0, 2, 2);
        run(3'd4, 3'd1, 8'h03, 1'b1, 1'b0, 1, 1);
        run(3'd2, 3'd6, 8'h00, 1'b0, 1'b0, SEL_TMO - 1, 1);
        run(3'd2, 3'd6, 8'h00, 1'b0, 1'b0, SEL_TMO, 1);
        run(3'd5, 3'd3, 8'h40, 1'b0, 1'b1, 3, 2);
        run(3'd6, 3'd1, 8'h00, 1'b0, 1'b1, SEL_TMO + 1, 1);

        for (int n = 0; n < 40; n++) begin
            o = 3'($urandom_range(0, 7));
            t = 3'(o + 3'($urandom_range(1, 7)));
            c = 8'($urandom_range(0, 255)) & ~lane(o);
            if ($urandom_range(0, 2) == 0) c = 8'h00;
            run(o, t, c, ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
                $urandom_range(0, SEL_TMO + 1), $urandom_range(1, 4));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule